// File: doc/BRIEF.md
# SD Four-Line Data Block Writer

This block writes one data block to an SD card over the four-bit data bus. After a start request it first waits for the card to release DAT0 from its busy state. It then drives a start bit, the block payload as nibbles, a separate CRC16 for each data line, and an end bit. It releases the bus and clocks in the card's CRC status token from DAT0. The payload arrives one byte at a time on a ready/valid stream. At the end the block gives a single-cycle done pulse, with a pass flag and a result code.

The card clock is not free-running. Every card clock is a single pulse built from the system clock by a programmable divider, so a slow producer simply stalls the bus between pulses. The divider is latched at start. A divide of three is the normal fast setting, and large values give the slow rate that card bring-up needs. Two programmable limits bound the card's behaviour. One is a cycle limit on the busy wait. The other is a pulse limit on the search for the status token.

Top module: `sd4_blk_writer`

## Requirements
- R1: After reset `dat_oe`, `sd_clk`, `s_ready` and `done` are 0. `start` is only taken while the block is idle, so one block gives exactly one `done` pulse even if `start` is raised again mid-transfer.
- R2: While DAT0 reads low after a start, no clock pulse is issued and `dat_oe` stays 0. The transfer begins once DAT0 reads high.
- R3: If DAT0 is still low when the busy counter reaches `busy_limit` cycles, the block ends with `ok`=0 and `err`=1, having issued no clock pulse and never driven the bus.
- R4: The first driven pulse carries 0 on all four lines (start bit). Next come 1024 payload nibbles: each byte sends its upper nibble first, and nibble bit k goes on DAT line k.
- R5: Each line then carries 16 CRC bits, MSB first. Each CRC is x^16+x^12+x^5+1, starts at zero and covers that line's 1024 payload bits. A final pulse follows with 1 on all four lines (end bit).
- R6: With the producer never stalling, clock pulses during the payload repeat every `clk_div` system cycles, where values below 2 count as 2. Each pulse is high for floor(`clk_div`/2) cycles, and `dat_out` only changes while `sd_clk` is low.
- R7: Once the end-bit pulse has finished, `dat_oe` drops. It does so while `sd_clk` is low and before any status pulse, and every later pulse in that block is issued with `dat_oe` low.
- R8: DAT0 is sampled just before each status rising edge. Pulses stop with the pulse whose sample completes the six-sample run high, low, c2, c1, c0, high. A card that shows two idle-high samples before its start bit therefore gets exactly 7 status pulses. The trailing sample is never taken. c2..c0 = 010 ends with `ok`=1 and `err`=0.
- R9: Any other status value c2..c0 ends with `ok`=0 and `err`=2.
- R10: If no valid token appears within `stat_limit` status pulses, the block ends after exactly that many pulses with `ok`=0 and `err`=3.
- R11: `s_ready` is high only during the payload phase while the single byte slot is empty. A producer that stalls delays the clock, but no byte is lost or repeated.
- R12: `done` lasts exactly one cycle. `ok` and `err` are valid with it and hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one block write (taken when idle) |
| clk_div | input | DIV_W | System cycles per card clock pulse |
| busy_limit | input | TMO_W | Busy-wait limit in system cycles |
| stat_limit | input | TMO_W | Status search limit in clock pulses |
| s_data | input | 8 | Payload byte |
| s_valid | input | 1 | Payload byte valid |
| s_ready | output | 1 | Block can take a payload byte |
| sd_clk | output | 1 | Card clock |
| dat_out | output | 4 | Data lines driven value |
| dat_oe | output | 1 | Data line output enable |
| dat0_in | input | 1 | DAT0 as read back from the card |
| done | output | 1 | One-cycle end-of-block pulse |
| ok | output | 1 | Block accepted by the card |
| err | output | 2 | 0 none, 1 busy timeout, 2 CRC rejected, 3 status timeout |

## Verification
A nibble or CRC counter that is off by one moves the CRC field and the end bit by one pulse, which shows in the capture before the bus is released. A byte-slot flag that is set or cleared at the wrong time shows as a repeated or skipped payload nibble at the next handshake. A stale or mis-aligned status window shows at once as one pulse too many or too few in the status phase, or as a wrong `err` code on `done`. A pulse generator that restarts in the wrong cycle shows on the first measured clock period and high time.

// File: rtl/sd4_pkg.sv
package sd4_pkg;
  localparam logic [15:0] CRC_POLY    = 16'h1021;
  localparam logic [2:0]  STAT_ACCEPT = 3'b010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BUSY, ST_START, ST_DATA, ST_GAP,
    ST_CRC, ST_END, ST_REL, ST_STAT
  } wr_state_e;

  typedef enum logic [1:0] {
    RES_NONE     = 2'd0,
    RES_BUSY_TMO = 2'd1,
    RES_CRC_REJ  = 2'd2,
    RES_STAT_TMO = 2'd3
  } wr_result_e;
endpackage

// File: rtl/sd4_clk_pulser.sv
// Issues single card-clock pulses of div system cycles each.
// Clock is low for the first ceil(div/2) cycles, high for the rest.
// A new pulse may be accepted in the last cycle of the current one.
module sd4_clk_pulser #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             go,
  output logic             sd_clk,
  output logic             ready,
  output logic             idle,
  output logic             pre_rise
);
  logic [DIV_W-1:0] div_eff, lo_len, cnt_q, n_cnt;
  logic             busy_q, n_busy, last;

  always_comb begin
    div_eff = (div < DIV_W'(2)) ? DIV_W'(2) : div;
    lo_len  = div_eff - (div_eff >> 1);
  end

  assign last     = busy_q && (cnt_q == div_eff - DIV_W'(1));
  assign ready    = !busy_q || last;
  assign idle     = !busy_q;
  assign pre_rise = busy_q && !last && (cnt_q + DIV_W'(1) == lo_len);

  always_comb begin
    n_busy = busy_q;
    n_cnt  = cnt_q;
    if (go && ready) begin
      n_busy = 1'b1;
      n_cnt  = '0;
    end else if (busy_q) begin
      if (last) begin
        n_busy = 1'b0;
        n_cnt  = '0;
      end else begin
        n_cnt = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sd_clk <= 1'b0;
    end else begin
      busy_q <= n_busy;
      cnt_q  <= n_cnt;
      sd_clk <= n_busy && (n_cnt >= lo_len);
    end
  end
endmodule

// File: rtl/sd4_crc16_lane.sv
// Serial CRC16 for one data line: feed payload bits, then shift out MSB first.
module sd4_crc16_lane #(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic feed,
  input  logic shift,
  input  logic din,
  output logic msb
);
  logic [15:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc_q <= '0;
    end else if (feed) begin
      crc_q <= {crc_q[14:0], 1'b0} ^ ((din ^ crc_q[15]) ? POLY : 16'h0000);
    end else if (shift) begin
      crc_q <= {crc_q[14:0], 1'b0};
    end
  end

  assign msb = crc_q[15];
endmodule

// File: rtl/sd4_status_rx.sv
// Sliding window over DAT0 samples; recognises idle-high, start, 3 status, stop.
module sd4_status_rx #(
  parameter int WIN = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       sample,
  input  logic       din,
  output logic       frame_ok,
  output logic [2:0] code
);
  logic [WIN-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      win_q <= '0;
    end else if (sample) begin
      win_q <= {win_q[WIN-2:0], din};
    end
  end

  assign frame_ok = win_q[WIN-1] && !win_q[WIN-2] && win_q[0];
  assign code     = win_q[WIN-3:1];
endmodule

// File: rtl/sd4_blk_writer.sv
module sd4_blk_writer
  import sd4_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int DIV_W       = 8,
  parameter int TMO_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [TMO_W-1:0] busy_limit,
  input  logic [TMO_W-1:0] stat_limit,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  output logic             sd_clk,
  output logic [3:0]       dat_out,
  output logic             dat_oe,
  input  logic             dat0_in,
  output logic             done,
  output logic             ok,
  output logic [1:0]       err
);
  localparam int LANES    = 4;
  localparam int NIBBLES  = BLOCK_BYTES * 2;
  localparam int NIB_W    = $clog2(NIBBLES);
  localparam int CRC_BITS = 16;
  localparam int CIDX_W   = $clog2(CRC_BITS);
  localparam logic [NIB_W-1:0]  NIB_LAST = NIB_W'(NIBBLES - 1);
  localparam logic [CIDX_W-1:0] CRC_LAST = CIDX_W'(CRC_BITS - 1);

  wr_state_e         state;
  logic [DIV_W-1:0]  div_q;
  logic [TMO_W-1:0]  bcnt, scnt;
  logic [NIB_W-1:0]  nib;
  logic [CIDX_W-1:0] cidx;
  logic [7:0]        byte_q;
  logic              byte_full;
  logic [3:0]        dat_q, nib_now, crc_msb;
  logic              oe_q, done_q, ok_q;
  logic [1:0]        err_q;
  logic              p_ready, p_idle, pre_rise, go;
  logic              crc_clr, crc_feed, crc_shift;
  logic              frame_ok;
  logic [2:0]        code;

  sd4_clk_pulser #(.DIV_W(DIV_W)) u_pulser (
    .clk(clk), .rst(rst), .div(div_q), .go(go),
    .sd_clk(sd_clk), .ready(p_ready), .idle(p_idle), .pre_rise(pre_rise)
  );

  assign nib_now   = nib[0] ? byte_q[3:0] : byte_q[7:4];
  assign crc_clr   = (state == ST_START) && go;
  assign crc_feed  = (state == ST_DATA) && go;
  assign crc_shift = (state == ST_CRC) && go;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sd4_crc16_lane #(.POLY(CRC_POLY)) u_lane (
      .clk(clk), .rst(rst), .clr(crc_clr), .feed(crc_feed),
      .shift(crc_shift), .din(nib_now[g]), .msb(crc_msb[g])
    );
  end

  sd4_status_rx u_status (
    .clk(clk), .rst(rst), .clr(state == ST_REL),
    .sample((state == ST_STAT) && pre_rise), .din(dat0_in),
    .frame_ok(frame_ok), .code(code)
  );

  always_comb begin
    case (state)
      ST_START, ST_CRC, ST_END: go = p_ready;
      ST_DATA: go = p_ready && byte_full;
      ST_STAT: go = p_ready && !frame_ok && (scnt != stat_limit);
      default: go = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      div_q     <= DIV_W'(2);
      bcnt      <= '0;
      scnt      <= '0;
      nib       <= '0;
      cidx      <= '0;
      byte_q    <= '0;
      byte_full <= 1'b0;
      dat_q     <= '0;
      oe_q      <= 1'b0;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
      err_q     <= RES_NONE;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          div_q <= clk_div;
          bcnt  <= '0;
          ok_q  <= 1'b0;
          err_q <= RES_NONE;
          state <= ST_BUSY;
        end
        ST_BUSY: begin
          if (dat0_in) begin
            state <= ST_START;
          end else if (bcnt == busy_limit) begin
            done_q <= 1'b1;
            err_q  <= RES_BUSY_TMO;
            state  <= ST_IDLE;
          end else begin
            bcnt <= bcnt + TMO_W'(1);
          end
        end
        ST_START: if (go) begin
          dat_q     <= 4'h0;
          oe_q      <= 1'b1;
          nib       <= '0;
          byte_full <= 1'b0;
          state     <= ST_DATA;
        end
        ST_DATA: begin
          if (s_valid && !byte_full) begin
            byte_q    <= s_data;
            byte_full <= 1'b1;
          end else if (go) begin
            dat_q <= nib_now;
            if (nib[0]) byte_full <= 1'b0;
            if (nib == NIB_LAST) state <= ST_GAP;
            else                 nib   <= nib + NIB_W'(1);
          end
        end
        ST_GAP: begin
          cidx  <= '0;
          state <= ST_CRC;
        end
        ST_CRC: if (go) begin
          dat_q <= crc_msb;
          if (cidx == CRC_LAST) state <= ST_END;
          else                  cidx  <= cidx + CIDX_W'(1);
        end
        ST_END: if (go) begin
          dat_q <= 4'hF;
          state <= ST_REL;
        end
        ST_REL: if (p_idle) begin
          oe_q  <= 1'b0;
          scnt  <= '0;
          state <= ST_STAT;
        end
        ST_STAT: begin
          if (frame_ok) begin
            done_q <= 1'b1;
            ok_q   <= (code == STAT_ACCEPT);
            err_q  <= (code == STAT_ACCEPT) ? RES_NONE : RES_CRC_REJ;
            state  <= ST_IDLE;
          end else if (p_ready) begin
            if (scnt == stat_limit) begin
              done_q <= 1'b1;
              err_q  <= RES_STAT_TMO;
              state  <= ST_IDLE;
            end else begin
              scnt <= scnt + TMO_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign s_ready = (state == ST_DATA) && !byte_full;
  assign dat_out = dat_q;
  assign dat_oe  = oe_q;
  assign done    = done_q;
  assign ok      = ok_q;
  assign err     = err_q;
endmodule

// File: rtl/sd4_blk_writer_chk.sv
module sd4_blk_writer_chk (
  input logic       clk,
  input logic       rst,
  input logic       sd_clk,
  input logic [3:0] dat_out,
  input logic       dat_oe,
  input logic       s_ready,
  input logic       done,
  input logic       ok,
  input logic [1:0] err
);
  p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_accept_clean_r8: assert property (@(posedge clk) disable iff (rst)
    (done && ok) |-> (err == 2'd0));

  p_reject_coded_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !ok) |-> (err != 2'd0));

  p_ready_in_payload_r11: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> dat_oe);

  p_data_hold_high_r6: assert property (@(posedge clk) disable iff (rst)
    (sd_clk && $past(sd_clk)) |-> $stable(dat_out));

  p_start_bit_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(dat_oe) |-> (dat_out == 4'h0 && !sd_clk));

  p_release_after_end_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(dat_oe) |-> ($past(dat_out) == 4'hF && !sd_clk));
endmodule

bind sd4_blk_writer sd4_blk_writer_chk u_chk (
  .clk(clk), .rst(rst), .sd_clk(sd_clk), .dat_out(dat_out), .dat_oe(dat_oe),
  .s_ready(s_ready), .done(done), .ok(ok), .err(err)
);

// File: tb/sd4_blk_writer_test.sv
module sd4_blk_writer_test;
  localparam int BB = 512;
  localparam int NPULSE = 1042;
  localparam int CAPN = 1200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] clk_div = 8'd3;
  logic [15:0] busy_limit = 16'd100;
  logic [15:0] stat_limit = 16'd40;
  logic [7:0] s_data = 8'h00;
  logic       s_valid = 1'b0;
  logic       s_ready, sd_clk, dat_oe, done, ok;
  logic [3:0] dat_out;
  logic       dat0_in = 1'b1;
  logic [1:0] err;

  always #2 clk = ~clk;

  sd4_blk_writer uut (
    .clk(clk), .rst(rst), .start(start), .clk_div(clk_div),
    .busy_limit(busy_limit), .stat_limit(stat_limit),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .sd_clk(sd_clk), .dat_out(dat_out), .dat_oe(dat_oe), .dat0_in(dat0_in),
    .done(done), .ok(ok), .err(err)
  );

  int checks = 0, fails = 0;
  logic [7:0]  blk [0:BB-1];
  logic [15:0] ecrc [0:3];
  logic [3:0]  cap [0:CAPN-1];
  int rise_t [0:CAPN-1];
  int ncap = 0, nstat = 0, nrise = 0, cyc = 0;
  int hi_run = 0, hi_last = 0, done_cnt = 0, done_w = 0, done_wmax = 0;
  int rel_rises = 0, rel_oe = 0;
  bit fin = 1'b0, wd_hit = 1'b0;

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge sd_clk) begin
    nrise++;
    if (dat_oe) begin
      if (ncap < CAPN) begin
        cap[ncap] = dat_out;
        rise_t[ncap] = cyc;
      end
      ncap++;
    end else begin
      nstat++;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (sd_clk) hi_run++;
    else begin
      if (hi_run > 0) hi_last = hi_run;
      hi_run = 0;
    end
    if (done) begin
      done_cnt++;
      done_w++;
      if (done_w > done_wmax) done_wmax = done_w;
    end else done_w = 0;
    if (cyc > 190000 && !wd_hit) begin
      wd_hit = 1'b1;
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [3:0] exp_nib(input int k);
    logic [3:0] n;
    if (k == 0) return 4'h0;
    if (k <= 1024) return ((k - 1) % 2 == 0) ? blk[(k-1)/2][7:4] : blk[(k-1)/2][3:0];
    if (k <= 1040) begin
      for (int l = 0; l < 4; l++) n[l] = ecrc[l][15-(k-1025)];
      return n;
    end
    return 4'hF;
  endfunction

  function automatic logic [15:0] lane_crc(input int lane);
    logic [15:0] c = 16'h0;
    logic b;
    for (int k = 1; k <= 1024; k++) begin
      b = exp_nib(k)[lane];
      c = {c[14:0], 1'b0} ^ ((b ^ c[15]) ? 16'h1021 : 16'h0);
    end
    return c;
  endfunction

  // dv: divider, bcyc: busy cycles (-1 never), idle_d: idle samples before token (-1 none)
  task automatic run_block(input int dv, input int bcyc, input int btmo, input int stmo,
                           input int idle_d, input logic [2:0] code, input bit gaps,
                           input bit again, input string tag);
    bit seq [0:63];
    int dve, bad, first;
    for (int i = 0; i < BB; i++) blk[i] = 8'($urandom);
    for (int l = 0; l < 4; l++) ecrc[l] = lane_crc(l);
    for (int i = 0; i < 64; i++) seq[i] = 1'b1;
    if (idle_d >= 0) begin
      seq[idle_d] = 1'b0;
      seq[idle_d+1] = code[2];
      seq[idle_d+2] = code[1];
      seq[idle_d+3] = code[0];
    end
    dve = (dv < 2) ? 2 : dv;
    @(negedge clk);
    clk_div = 8'(dv); busy_limit = 16'(btmo); stat_limit = 16'(stmo);
    dat0_in = (bcyc == 0);
    ncap = 0; nstat = 0; nrise = 0; done_cnt = 0; done_wmax = 0; fin = 1'b0;
    rel_rises = 0; rel_oe = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      begin : producer
        int i = 0;
        while (i < BB && !fin) begin
          @(negedge clk);
          s_valid = gaps ? (($urandom % 4) != 0) : 1'b1;
          s_data = blk[i];
          if (s_valid && s_ready) i++;
        end
        @(negedge clk);
        s_valid = 1'b0;
      end
      begin : busy_release
        if (bcyc > 0) begin
          repeat (bcyc) @(negedge clk);
          rel_rises = nrise;
          rel_oe = dat_oe;
          dat0_in = 1'b1;
        end
      end
      begin : card
        int idx = 0;
        wait (dat_oe || fin);
        if (!fin) begin
          wait (!dat_oe);
          dat0_in = seq[0];
          while (!fin) begin
            @(negedge sd_clk or posedge fin);
            if (!fin) begin
              idx++;
              dat0_in = (idx < 64) ? seq[idx] : 1'b1;
            end
          end
        end
      end
      begin : waiter
        wait (done_cnt > 0);
        repeat (4) @(negedge clk);
        fin = 1'b1;
      end
      begin : restart
        if (again) begin
          repeat (300) @(negedge clk);
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
    dat0_in = 1'b1;
    chk(done_wmax == 1, "R12", {tag, " done width"}, done_wmax, 1);
    chk(done_cnt == 1, "R1", {tag, " done count"}, done_cnt, 1);
    if (idle_d >= 0 && bcyc >= 0) begin
      chk(ncap == NPULSE, "R4", {tag, " driven pulses"}, ncap, NPULSE);
      bad = 0; first = -1;
      for (int k = 0; k <= 1024; k++)
        if (k < ncap && cap[k] !== exp_nib(k)) begin bad++; if (first < 0) first = k; end
      chk(bad == 0, gaps ? "R11" : "R4", {tag, " payload nibbles (first bad index)"}, first, -1);
      bad = 0; first = -1;
      for (int k = 1025; k <= 1041; k++)
        if (k < ncap && cap[k] !== exp_nib(k)) begin bad++; if (first < 0) first = k; end
      chk(bad == 0, "R5", {tag, " crc and end bit (first bad index)"}, first, -1);
      chk(nstat == idle_d + 5, "R8", {tag, " status pulses"}, nstat, idle_d + 5);
      chk(ok == (code == 3'b010), (code == 3'b010) ? "R8" : "R9", {tag, " ok"}, ok, code == 3'b010);
      chk(err == ((code == 3'b010) ? 2'd0 : 2'd2), (code == 3'b010) ? "R8" : "R9",
          {tag, " err"}, err, (code == 3'b010) ? 0 : 2);
      chk(hi_last == dve / 2, "R6", {tag, " clock high cycles"}, hi_last, dve / 2);
      chk(dat_oe == 1'b0, "R7", {tag, " bus released at end"}, dat_oe, 0);
      if (!gaps) begin
        bad = 0; first = 0;
        for (int k = 2; k < 1000; k++)
          if (rise_t[k] - rise_t[k-1] != dve) begin bad++; first = rise_t[k] - rise_t[k-1]; end
        chk(bad == 0, "R6", {tag, " pulse period"}, first, dve);
      end
      if (bcyc > 0) begin
        chk(rel_rises == 0 && rel_oe == 0, "R2", {tag, " quiet during busy"},
            rel_rises + rel_oe, 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dat_oe == 0 && sd_clk == 0, "R1", "reset bus idle", {dat_oe, sd_clk}, 0);
    chk(s_ready == 0 && done == 0, "R1", "reset handshake idle", {s_ready, done}, 0);

    run_block(3, 20, 1000, 40, 2, 3'b010, 1'b0, 1'b0, "A");
    repeat (10) @(negedge clk);
    chk(ok == 1 && err == 0, "R12", "result held", {ok, err}, 4);
    run_block(2, 0, 1000, 40, 1, 3'b101, 1'b1, 1'b0, "B");
    run_block(5, 7, 1000, 40, 4, 3'b010, 1'b1, 1'b1, "C");
    run_block(1, 0, 1000, 40, 2, 3'b011, 1'b0, 1'b0, "D");

    run_block(3, -1, 50, 40, 2, 3'b010, 1'b0, 1'b0, "E");
    chk(ok == 0 && err == 2'd1, "R3", "busy timeout result", {ok, err}, 1);
    chk(nrise == 0 && ncap == 0, "R3", "no pulses on busy timeout", nrise, 0);

    run_block(2, 0, 1000, 12, -1, 3'b010, 1'b0, 1'b0, "F");
    chk(ok == 0 && err == 2'd3, "R10", "status timeout result", {ok, err}, 3);
    chk(nstat == 12, "R10", "status timeout pulses", nstat, 12);
    chk(ncap == NPULSE, "R7", "pulses driven before release", ncap, NPULSE);

    for (int r = 0; r < 3; r++) begin
      run_block(2 + int'($urandom % 5), int'($urandom % 30), 1000, 40,
                1 + int'($urandom % 6), 3'($urandom), 1'b1, 1'b0, "RND");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule